// File: doc/BRIEF.md
# I2S Slave Audio Receiver

This block receives a serial audio stream as the slave on an I2S-style link. An external master drives the bit clock and word select, and the block never generates a clock. All three link inputs pass through synchronizers into the system clock domain. Data is taken on rising bit-clock edges, most significant bit first. Four framing standards are supported: Philips I2S, MSB-justified, LSB-justified and a short-pulse PCM frame. Samples may be 16, 24 or 32 bits wide and sit in a 16-bit or 32-bit channel slot.

Each sample is handed to the host as one or two halfwords through a single 16-bit holding register. A not-empty flag, a channel-side flag and an overrun flag go with it, plus two interrupt outputs that the host can mask. The host uses read strobes in place of a bus. A data-read strobe takes the held halfword, and a status-read strobe completes the overrun clearing sequence. An enable input starts and stops reception. It only takes effect at frame boundaries, so a frame is never cut in half.

Top module: `i2sSlaveRx`

## Requirements
- R1: After reset, `dataOut` is 0 and `rxNotEmpty`, `chanSide`, `overrun`, `irqRx` and `irqErr` are all low.
- R2: `stdSel` picks the framing. In all four modes the data bit is taken on the rising bit-clock edge, MSB first.
  - 2'b00 (Philips): the MSB comes one bit after the word-select change.
  - 2'b01 (MSB-justified): the MSB is on the bit where word select changes.
  - 2'b10 (LSB-justified): the data is right-aligned so that its LSB is the last bit of the slot.
  - 2'b11 (PCM): a one-bit word-select high pulse comes one bit before the MSB, and each frame is a single slot.
- R3: `dataLen` 2'b00 selects 16-bit samples, 2'b01 24-bit and 2'b10 32-bit. The slot is 32 bits when `chanLong` is 1 or the sample is wider than 16 bits, and 16 bits otherwise.
- R4: A 16-bit sample gives one halfword. A wider sample gives two halfwords, the upper one first. For 24-bit samples the second halfword carries the low 8 sample bits in its upper byte, with zeros below.
- R5: `rxNotEmpty` rises when a halfword lands in `dataOut`. A `rdData` pulse clears it.
- R6: `chanSide` is updated with every landed halfword. It is 0 for a slot framed by word select low (left) and 1 for word select high (right). It is always 0 in PCM mode.
- R7: A halfword that arrives while `rxNotEmpty` is high sets `overrun` and is discarded. `dataOut` and `chanSide` keep their old values.
- R8: `overrun` is cleared only by a `rdData` pulse followed later by a `rdStatus` pulse. A `rdStatus` pulse with no earlier data read leaves it set.
- R9: `irqRx` is high when `rxNotEmpty` and `rxIrqEn` are both high. `irqErr` is high when `overrun` and `errIrqEn` are both high.
- R10: `busy` stays low at all times, including during transfers.
- R11: `rxEnable` is sampled only at frame starts. A frame start is the start of a left slot, or in PCM mode the start of every frame. Clearing the enable mid-frame lets the rest of that frame arrive. Setting it mid-frame delivers nothing until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | Bit clock from the external master |
| wsIn | input | 1 | Word select from the external master |
| sdIn | input | 1 | Serial data |
| rxEnable | input | 1 | Reception enable, taken at frame starts |
| stdSel | input | 2 | Framing standard |
| dataLen | input | 2 | Sample length code |
| chanLong | input | 1 | 1 = 32-bit slot for 16-bit data |
| rxIrqEn | input | 1 | Receive interrupt mask |
| errIrqEn | input | 1 | Overrun interrupt mask |
| rdData | input | 1 | Data-register read strobe |
| rdStatus | input | 1 | Status-register read strobe |
| dataOut | output | 16 | Held halfword |
| rxNotEmpty | output | 1 | Halfword waiting |
| chanSide | output | 1 | Channel of the held halfword |
| overrun | output | 1 | Data lost |
| busy | output | 1 | Always low |
| irqRx | output | 1 | Receive interrupt |
| irqErr | output | 1 | Overrun interrupt |

## Verification
A slot counter or window start that is off by one shifts every sample by one bit. That error appears in the first halfword after a slot boundary, so the first compared word shows it. A wrong latched channel or enable state shows up within one frame, as a swapped `chanSide` or as a missing or extra halfword. A fault in the holding-register flags, such as a missed overrun, overwritten data, or an overrun that clears on a status read alone, shows at the flags in the cycle after the strobe that should change them.

// File: rtl/i2sRxPkg.sv
package i2sRxPkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(WORD_W) + 1;
  localparam int PAD_W  = HALF_W / 2;

  typedef enum logic [1:0] {
    STD_PHILIPS = 2'b00,
    STD_MSB     = 2'b01,
    STD_LSB     = 2'b10,
    STD_PCM     = 2'b11
  } rxStdE;

  // strobes from framing control to the holding datapath
  typedef struct packed {
    logic shift;   // take bitVal into the shift register
    logic bitVal;  // sampled serial bit
    logic push;    // a halfword is complete this cycle
    logic pad8;    // second halfword of a 24-bit sample
    logic side;    // channel of the current slot
  } rxStrobeT;
endpackage

// File: rtl/i2sRxCtrl.sv
module i2sRxCtrl
  import i2sRxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckIn,
  input  logic       wsIn,
  input  logic       sdIn,
  input  logic       rxEnable,
  input  logic [1:0] stdSel,
  input  logic [1:0] dataLen,
  input  logic       chanLong,
  output rxStrobeT   strobe
);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF_W);
  localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(HALF_W + PAD_W);

  logic [SYNC_STAGES-1:0] sckSh, wsSh, sdSh;
  logic sckSync, wsSync, sdSync, sckPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSh <= '0;
      wsSh  <= '0;
      sdSh  <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSh <= {sckSh[SYNC_STAGES-2:0], sckIn};
      wsSh  <= {wsSh[SYNC_STAGES-2:0], wsIn};
      sdSh  <= {sdSh[SYNC_STAGES-2:0], sdIn};
      sckPrev <= sckSync;
    end
  end

  assign sckSync = sckSh[SYNC_STAGES-1];
  assign wsSync  = wsSh[SYNC_STAGES-1];
  assign sdSync  = sdSh[SYNC_STAGES-1];

  logic wsDly, effPrev, active, slotSide;
  logic [CNT_W-1:0] bitCnt;

  logic isPcm, useDly, isLsb, rise, effWs, slotStart, frameStart;
  logic activeNow, sideNow, inWin;
  logic [CNT_W-1:0] dBits, sBits, kNow, winLo, jIdx;

  always_comb begin
    isPcm  = (stdSel == STD_PCM);
    useDly = (stdSel == STD_PHILIPS) || isPcm;
    isLsb  = (stdSel == STD_LSB);
    case (dataLen)
      2'b01:   dBits = MID_C;
      2'b10:   dBits = WORD_C;
      default: dBits = HALF_C;
    endcase
    sBits = (chanLong || dBits != HALF_C) ? WORD_C : HALF_C;
    rise  = sckSync & ~sckPrev;
    effWs = useDly ? wsDly : wsSync;
    slotStart  = rise & (isPcm ? (effWs & ~effPrev) : (effWs ^ effPrev));
    frameStart = slotStart & (isPcm | ~effWs);
    if (slotStart)        kNow = '0;
    else if (&bitCnt)     kNow = bitCnt;
    else                  kNow = bitCnt + 1'b1;
    activeNow = frameStart ? rxEnable : active;
    sideNow   = slotStart ? (~isPcm & effWs) : slotSide;
    winLo = isLsb ? (sBits - dBits) : '0;
    jIdx  = kNow - winLo;
    inWin = activeNow && (kNow >= winLo) && (kNow < winLo + dBits);

    strobe.shift  = rise & inWin;
    strobe.bitVal = sdSync;
    strobe.push   = rise & inWin &
                    ((jIdx == HALF_C - 1'b1) ||
                     ((jIdx == dBits - 1'b1) && (dBits != HALF_C)));
    strobe.pad8   = (dBits == MID_C) && (jIdx == MID_C - 1'b1);
    strobe.side   = sideNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wsDly    <= 1'b0;
      effPrev  <= 1'b0;
      active   <= 1'b0;
      slotSide <= 1'b0;
      bitCnt   <= '1;  // saturated: outside any window until a slot starts
    end else if (rise) begin
      wsDly   <= wsSync;
      effPrev <= effWs;
      bitCnt  <= kNow;
      if (slotStart)  slotSide <= ~isPcm & effWs;
      if (frameStart) active   <= rxEnable;
    end
  end
endmodule

// File: rtl/i2sRxRegs.sv
module i2sRxRegs
  import i2sRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strobe,
  input  logic              rdData,
  input  logic              rdStatus,
  input  logic              rxIrqEn,
  input  logic              errIrqEn,
  output logic [HALF_W-1:0] dataOut,
  output logic              rxNotEmpty,
  output logic              chanSide,
  output logic              overrun,
  output logic              irqRx,
  output logic              irqErr
);
  logic [HALF_W-1:0] shReg, nextSh, pushVal;
  logic clrArmed;

  always_comb begin
    nextSh  = {shReg[HALF_W-2:0], strobe.bitVal};
    pushVal = strobe.pad8 ? {nextSh[PAD_W-1:0], {PAD_W{1'b0}}} : nextSh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg      <= '0;
      dataOut    <= '0;
      rxNotEmpty <= 1'b0;
      chanSide   <= 1'b0;
      overrun    <= 1'b0;
      clrArmed   <= 1'b0;
    end else begin
      if (strobe.shift) shReg <= nextSh;
      if (rdData) begin
        rxNotEmpty <= 1'b0;
        if (overrun) clrArmed <= 1'b1;
      end
      if (strobe.push) begin
        if (rxNotEmpty && !rdData) begin
          overrun <= 1'b1;
        end else begin
          dataOut    <= pushVal;
          chanSide   <= strobe.side;
          rxNotEmpty <= 1'b1;
        end
      end
      if (rdStatus && clrArmed) begin
        overrun  <= 1'b0;
        clrArmed <= 1'b0;
      end
    end
  end

  assign irqRx  = rxNotEmpty & rxIrqEn;
  assign irqErr = overrun & errIrqEn;
endmodule

// File: rtl/i2sSlaveRx.sv
module i2sSlaveRx
  import i2sRxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckIn,
  input  logic        wsIn,
  input  logic        sdIn,
  input  logic        rxEnable,
  input  logic [1:0]  stdSel,
  input  logic [1:0]  dataLen,
  input  logic        chanLong,
  input  logic        rxIrqEn,
  input  logic        errIrqEn,
  input  logic        rdData,
  input  logic        rdStatus,
  output logic [15:0] dataOut,
  output logic        rxNotEmpty,
  output logic        chanSide,
  output logic        overrun,
  output logic        busy,
  output logic        irqRx,
  output logic        irqErr
);
  rxStrobeT strobe;

  i2sRxCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .rxEnable(rxEnable), .stdSel(stdSel), .dataLen(dataLen),
    .chanLong(chanLong), .strobe(strobe)
  );

  i2sRxRegs uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .rdStatus(rdStatus), .rxIrqEn(rxIrqEn), .errIrqEn(errIrqEn),
    .dataOut(dataOut), .rxNotEmpty(rxNotEmpty), .chanSide(chanSide),
    .overrun(overrun), .irqRx(irqRx), .irqErr(irqErr)
  );

  assign busy = 1'b0;  // R10
endmodule

// File: rtl/i2sSlaveRxChk.sv
module i2sSlaveRxChk (
  input logic        clk,
  input logic        rstN,
  input logic        rdData,
  input logic        rdStatus,
  input logic        push,
  input logic [15:0] dataOut,
  input logic        rxNotEmpty,
  input logic        chanSide,
  input logic        overrun
);
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !push) |=> !rxNotEmpty);

  p_fill_needs_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxNotEmpty) |-> $past(push));

  p_ovr_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    (push && rxNotEmpty && !rdData) |=> overrun);

  p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    (push && rxNotEmpty && !rdData) |=> ($stable(dataOut) && $stable(chanSide)));

  p_ovr_from_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(push));

  p_ovr_clear_by_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> $past(rdStatus));
endmodule

bind i2sSlaveRx i2sSlaveRxChk uChk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .rdStatus(rdStatus),
  .push(strobe.push), .dataOut(dataOut), .rxNotEmpty(rxNotEmpty),
  .chanSide(chanSide), .overrun(overrun)
);

// File: tb/i2sSlaveRx_test.sv
module i2sSlaveRx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, wsIn = 1'b0, sdIn = 1'b0;
  logic rxEnable = 1'b0;
  logic [1:0] stdSel = 2'b01, dataLen = 2'b00;
  logic chanLong = 1'b0, rxIrqEn = 1'b0, errIrqEn = 1'b0;
  logic rdData = 1'b0, rdStatus = 1'b0;
  logic [15:0] dataOut;
  logic rxNotEmpty, chanSide, overrun, busy, irqRx, irqErr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2sSlaveRx uut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .rxEnable(rxEnable), .stdSel(stdSel), .dataLen(dataLen),
    .chanLong(chanLong), .rxIrqEn(rxIrqEn), .errIrqEn(errIrqEn),
    .rdData(rdData), .rdStatus(rdStatus), .dataOut(dataOut),
    .rxNotEmpty(rxNotEmpty), .chanSide(chanSide), .overrun(overrun),
    .busy(busy), .irqRx(irqRx), .irqErr(irqErr)
  );

  // host reader model
  bit autoRead = 0;
  logic [15:0] gotData [0:63];
  logic        gotSide [0:63];
  int gotN = 0;
  logic [15:0] expData [0:63];
  logic        expSide [0:63];
  int expN = 0;

  initial forever begin
    @(negedge clk);
    if (autoRead) begin
      if (rdData) rdData = 1'b0;
      else if (rxNotEmpty) begin
        if (gotN < 64) begin
          gotData[gotN] = dataOut;
          gotSide[gotN] = chanSide;
        end
        gotN++;
        rdData = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dBitsF();
    return (dataLen == 2'b01) ? 24 : (dataLen == 2'b10) ? 32 : 16;
  endfunction

  function automatic int sBitsF();
    return (chanLong || dBitsF() != 16) ? 32 : 16;
  endfunction

  function automatic logic bitAt(input int k, input logic [31:0] smp);
    int s = sBitsF();
    int d = dBitsF();
    if (stdSel == 2'b10) return (k >= s - d) ? smp[s-1-k] : 1'b0;
    return (k < d) ? smp[d-1-k] : 1'b0;
  endfunction

  task automatic addExp(input logic [31:0] smp, input logic side);
    logic [31:0] dd = smp << (32 - dBitsF());
    expData[expN] = dd[31:16]; expSide[expN] = side; expN++;
    if (dBitsF() > 16) begin
      expData[expN] = dd[15:0]; expSide[expN] = side; expN++;
    end
  endtask

  task automatic sendBit(input logic w, input logic d);
    @(negedge clk);
    sckIn = 1'b0; wsIn = w; sdIn = d;
    repeat (4) @(negedge clk);
    sckIn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendSlot(input logic baseWs, input logic lastWs, input logic [31:0] smp);
    for (int k = 0; k < sBitsF(); k++)
      sendBit((k == sBitsF() - 1) ? lastWs : baseWs, bitAt(k, smp));
  endtask

  task automatic doReset();
    @(negedge clk);
    sckIn = 1'b0; wsIn = 1'b0; sdIn = 1'b0; rstN = 1'b0;
    rdData = 1'b0; rdStatus = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  logic [31:0] smpL [0:7];
  logic [31:0] smpR [0:7];

  // slot-indexed enable changes: onAt / offAt (-1 = none)
  task automatic runFrames(input int nFr, input int onAt, input int offAt, input string tag);
    int d = dBitsF();
    int slot = 0;
    bit pcm = (stdSel == 2'b11);
    bit phil = (stdSel == 2'b00);
    bit frameOn;
    gotN = 0; expN = 0; autoRead = 1;
    for (int i = 0; i < nFr; i++) begin
      smpL[i] = ($urandom() << (32 - d)) >> (32 - d);
      smpR[i] = ($urandom() << (32 - d)) >> (32 - d);
    end
    if (pcm) sendSlot(1'b0, 1'b1, 32'h0);
    else     sendSlot(1'b1, phil ? 1'b0 : 1'b1, 32'h0);
    for (int i = 0; i < nFr; i++) begin
      if (slot == onAt) rxEnable = 1'b1;
      if (slot == offAt) rxEnable = 1'b0;
      frameOn = rxEnable;
      if (frameOn) addExp(smpL[i], 1'b0);
      if (pcm) begin
        sendSlot(1'b0, 1'b1, smpL[i]);
        slot++;
      end else begin
        sendSlot(1'b0, phil ? 1'b1 : 1'b0, smpL[i]);
        slot++;
        if (slot == onAt) rxEnable = 1'b1;
        if (slot == offAt) rxEnable = 1'b0;
        if (frameOn) addExp(smpR[i], 1'b1);
        sendSlot(1'b1, phil ? 1'b0 : 1'b1, smpR[i]);
        slot++;
      end
    end
    repeat (40) @(negedge clk);
    autoRead = 0;
    repeat (2) @(negedge clk);
    check(gotN == expN, {tag, " halfword count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotData[i] == expData[i], {tag, " data"}, gotData[i], expData[i]);
      check(gotSide[i] == expSide[i], {tag, " side"}, gotSide[i], expSide[i]);
    end
  endtask

  task automatic pulseData();
    @(negedge clk) rdData = 1'b1;
    @(negedge clk) rdData = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseStatus();
    @(negedge clk) rdStatus = 1'b1;
    @(negedge clk) rdStatus = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4177);
    doReset();
    @(negedge clk);
    // R1 / R10 reset state
    check(dataOut == 16'h0 && !rxNotEmpty && !chanSide && !overrun, "R1 reset flags",
          {dataOut, rxNotEmpty, chanSide, overrun}, 0);
    check(!irqRx && !irqErr, "R1 reset irqs", {irqRx, irqErr}, 0);
    check(busy == 1'b0, "R10 busy low at reset", busy, 0);

    // R2 R3 R4 R6: each standard, directed lengths
    for (int s = 0; s < 4; s++) begin
      stdSel = 2'(s); dataLen = 2'b00; chanLong = 1'b0;
      doReset(); rxEnable = 1'b1;
      runFrames(2, -1, -1, "R2 R6 16/16");
      stdSel = 2'(s); dataLen = 2'b00; chanLong = 1'b1;
      doReset(); rxEnable = 1'b1;
      runFrames(2, -1, -1, "R2 R3 16in32");
      stdSel = 2'(s); dataLen = 2'b01;
      doReset(); rxEnable = 1'b1;
      runFrames(2, -1, -1, "R3 R4 24-bit");
      stdSel = 2'(s); dataLen = 2'b10;
      doReset(); rxEnable = 1'b1;
      runFrames(2, -1, -1, "R3 R4 32-bit");
    end

    // R11: disable mid-frame finishes that frame
    stdSel = 2'b01; dataLen = 2'b00; chanLong = 1'b0;
    doReset(); rxEnable = 1'b1;
    runFrames(3, -1, 1, "R11 disable mid-frame");
    // R11: enable mid-frame waits for next frame start
    stdSel = 2'b00; dataLen = 2'b01;
    doReset(); rxEnable = 1'b0;
    runFrames(3, 1, -1, "R11 enable mid-frame");

    // R7 R8 R9 R5: overrun sequence
    stdSel = 2'b01; dataLen = 2'b00; chanLong = 1'b0;
    doReset(); rxEnable = 1'b1; rxIrqEn = 1'b1; errIrqEn = 1'b1;
    autoRead = 0;
    sendSlot(1'b1, 1'b1, 32'h0);
    sendSlot(1'b0, 1'b0, 32'h0000A5C3);
    repeat (8) @(negedge clk);
    check(rxNotEmpty && dataOut == 16'hA5C3 && !chanSide, "R5 first halfword",
          dataOut, 16'hA5C3);
    check(irqRx == 1'b1, "R9 irqRx with enable", irqRx, 1);
    check(busy == 1'b0, "R10 busy low during transfer", busy, 0);
    sendSlot(1'b1, 1'b1, 32'h00001234);
    repeat (8) @(negedge clk);
    check(overrun == 1'b1, "R7 overrun set", overrun, 1);
    check(dataOut == 16'hA5C3 && !chanSide, "R7 data kept", dataOut, 16'hA5C3);
    check(irqErr == 1'b1, "R9 irqErr with enable", irqErr, 1);
    errIrqEn = 1'b0;
    @(negedge clk);
    check(irqErr == 1'b0, "R9 irqErr masked", irqErr, 0);
    pulseStatus();
    check(overrun == 1'b1, "R8 status read alone keeps overrun", overrun, 1);
    pulseData();
    check(!rxNotEmpty, "R5 read clears rxNotEmpty", rxNotEmpty, 0);
    check(irqRx == 1'b0, "R9 irqRx follows flag", irqRx, 0);
    check(overrun == 1'b1, "R8 data read alone keeps overrun", overrun, 1);
    pulseStatus();
    check(overrun == 1'b0, "R8 data then status clears overrun", overrun, 0);
    rxIrqEn = 1'b0;

    // random mix of modes and lengths
    for (int t = 0; t < 8; t++) begin
      stdSel = 2'($urandom() % 4);
      dataLen = 2'($urandom() % 3);
      chanLong = 1'($urandom() % 2);
      doReset(); rxEnable = 1'b1;
      runFrames(3, -1, -1, "R2 R3 R4 R6 random");
    end

    finishRun();
  end
endmodule